// File: doc/BRIEF.md
# Full-Map Home Directory Controller

This block is the home node of a distributed shared memory system. For each memory line it owns, it keeps a directory entry with a stable state (uncached, shared or exclusive) and a full-map sharer vector that has one bit per cache. It also holds the line's data in a small internal array. Caches send it read misses, write misses, dirty write-backs and clean eviction notices. The directory answers with data replies. It sends invalidations or fetches to other caches when coherence requires it, and it collects their acknowledgements before it completes the original request.

When a request needs work from other caches, the line is marked busy. The entry then records how many acknowledgements are still due, which cache asked, whether it asked for write ownership, and whether the returning acknowledgement carries the line's latest data. Any further request for a busy line gets a negative acknowledgement (NACK), and the cache retries later. All three output channels are registered and appear one cycle after the input that causes them.

Top module: `hdir_ctrl`

## Requirements
- R1: After reset every line is uncached and holds data zero, and the reply, forward and NACK valid outputs are all low.
- R2: A read miss (req_type 0) to an uncached or shared line returns a data reply to the requester the next cycle, adds the requester to the sharers, and leaves the line shared.
- R3: A write miss (req_type 1) to an uncached line returns a data reply the next cycle and sends no forward message. The requester becomes the sole owner.
- R4: A write miss to a shared line multicasts one invalidate (fwd_kind 0) whose fwd_mask holds every sharer except the requester. An acknowledgement from a cache outside that mask is ignored. The data reply to the requester comes one cycle after the last expected acknowledgement.
- R5: A write miss to an exclusive line owned by another cache invalidates that owner. The owner's acknowledgement data is written to memory and forwarded to the requester, who becomes the sole owner.
- R6: A read miss to an exclusive line owned by another cache sends a fetch (fwd_kind 1) to the owner only. The owner's acknowledgement data updates memory and is replied to the reader, and the line becomes shared by both the old owner and the reader.
- R7: A write-back (req_type 2) from the exclusive owner stores req_data and makes the line uncached without replying. A write-back from a cache that is not the owner has no effect.
- R8: A request to a line that is waiting for acknowledgements gets a NACK to the requester the next cycle and changes nothing.
- R9: A request that arrives in the same cycle as the acknowledgement that completes a transaction is NACKed, because the reply channel is taken.
- R10: An eviction notice (req_type 3) to a shared line clears that cache's bit. When no sharer remains, the line becomes uncached.
- R11: A read or write miss from the current exclusive owner gets a data reply at once, with no forward message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request message present |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 eviction notice |
| req_src | input | log2(NCACHE) | Requesting cache |
| req_line | input | log2(NLINES) | Target line |
| req_data | input | DATA_W | Write-back data |
| ack_valid | input | 1 | Acknowledgement from a cache |
| ack_src | input | log2(NCACHE) | Acknowledging cache |
| ack_line | input | log2(NLINES) | Line acknowledged |
| ack_data | input | DATA_W | Line data carried by an owner's acknowledgement |
| rsp_valid | output | 1 | Data reply present |
| rsp_dst | output | log2(NCACHE) | Reply destination |
| rsp_line | output | log2(NLINES) | Reply line |
| rsp_data | output | DATA_W | Reply data |
| fwd_valid | output | 1 | Invalidate or fetch present |
| fwd_kind | output | 1 | 0 invalidate, 1 fetch |
| fwd_mask | output | NCACHE | Caches the forward message goes to |
| fwd_line | output | log2(NLINES) | Forwarded line |
| nack_valid | output | 1 | Retry notice present |
| nack_dst | output | log2(NCACHE) | Cache told to retry |
| nack_line | output | log2(NLINES) | Line refused |

## Verification
The bench builds the block with NCACHE=4, NLINES=8 and DATA_W=16. Four caches are enough for a two-sharer invalidation that leaves out the requester, an ignored stray acknowledgement from a fourth cache, and a fetch followed by a two-target invalidation. Eight lines let separate lines take part in the eviction and collision scenarios while other lines sit busy. The 16-bit data makes every memory update visible as a distinct reply value.

// File: rtl/hdir_pkg.sv
// Shared encodings for the home directory controller.
// Assumes request and forward codes match the port encodings listed in the brief.
package hdir_pkg;
    typedef enum logic [1:0] {
        LN_UNC = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2,
        RQ_EVICT = 2'd3
    } req_kind_e;

    localparam logic FW_INV   = 1'b0;
    localparam logic FW_FETCH = 1'b1;
endpackage

// File: rtl/hdir_store.sv
// Row-addressed register storage with two combinational read ports and two
// write ports. Rows reset to zero. Assumes the two write ports never target
// the same row in one cycle; if they do, port B wins.
module hdir_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_addr,
    output logic [WIDTH-1:0] ra_data,
    input  logic [AW-1:0]    rb_addr,
    output logic [WIDTH-1:0] rb_data,
    input  logic             wa_en,
    input  logic [AW-1:0]    wa_addr,
    input  logic [WIDTH-1:0] wa_data,
    input  logic             wb_en,
    input  logic [AW-1:0]    wb_addr,
    input  logic [WIDTH-1:0] wb_data
);
    logic [WIDTH-1:0] rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        // Update one row from whichever write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[i] <= '0;
            end else if (wb_en && wb_addr == AW'(i)) begin
                rows[i] <= wb_data;
            end else if (wa_en && wa_addr == AW'(i)) begin
                rows[i] <= wa_data;
            end
        end
    end

    // Asynchronous read of both ports.
    always_comb begin
        ra_data = rows[ra_addr];
        rb_data = rows[rb_addr];
    end
endmodule

// File: rtl/hdir_ack_unit.sv
// Acknowledgement evaluation for one busy directory entry. It decides whether
// an incoming acknowledgement belongs to the transaction, whether it is the
// last one due, and the sharer set the line settles to on completion.
// Assumes each target cache acknowledges once.
module hdir_ack_unit #(
    parameter int NCACHE = 4,
    localparam int IW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int CW = $clog2(NCACHE + 1)
) (
    input  logic              ack_valid,
    input  logic [IW-1:0]     ack_src,
    input  logic              busy,
    input  logic [CW-1:0]     cnt,
    input  logic [IW-1:0]     rqid,
    input  logic              rqwr,
    input  logic              wdat,
    input  logic [NCACHE-1:0] shr,
    output logic              hit,
    output logic              done,
    output logic [CW-1:0]     cnt_nx,
    output logic [NCACHE-1:0] fin_shr,
    output logic              fin_exc
);
    logic [NCACHE-1:0] rq_bit;
    logic [NCACHE-1:0] targets;

    // Work out who was asked, and the result of this acknowledgement.
    always_comb begin
        rq_bit          = '0;
        rq_bit[rqid]    = 1'b1;
        targets         = (rqwr && !wdat) ? (shr & ~rq_bit) : shr;
        hit             = ack_valid && busy && targets[ack_src];
        done            = hit && (cnt == CW'(1));
        cnt_nx          = cnt - CW'(1);
        fin_exc         = rqwr;
        fin_shr         = rqwr ? rq_bit : (shr | rq_bit);
    end
endmodule

// File: rtl/hdir_ctrl.sv
// Home directory controller with a full-map sharer vector per line.
// Serves read/write misses, owner write-backs and sharer evictions, sends
// invalidations and fetches, counts acknowledgements, and NACKs requests
// to busy lines. Assumes at most one request and one acknowledgement per cycle.
module hdir_ctrl
    import hdir_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int NLINES = 16,
    parameter int DATA_W = 32,
    localparam int IW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW = $clog2(NCACHE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_type,
    input  logic [IW-1:0]     req_src,
    input  logic [LW-1:0]     req_line,
    input  logic [DATA_W-1:0] req_data,
    input  logic              ack_valid,
    input  logic [IW-1:0]     ack_src,
    input  logic [LW-1:0]     ack_line,
    input  logic [DATA_W-1:0] ack_data,
    output logic              rsp_valid,
    output logic [IW-1:0]     rsp_dst,
    output logic [LW-1:0]     rsp_line,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fwd_valid,
    output logic              fwd_kind,
    output logic [NCACHE-1:0] fwd_mask,
    output logic [LW-1:0]     fwd_line,
    output logic              nack_valid,
    output logic [IW-1:0]     nack_dst,
    output logic [LW-1:0]     nack_line
);
    typedef struct packed {
        line_st_e          st;
        logic [NCACHE-1:0] shr;
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     rqid;
        logic              rqwr;
        logic              wdat;
    } dent_t;
    localparam int EW = $bits(dent_t);

    logic [EW-1:0]     eq_raw, ek_raw;
    dent_t             eq, ek, nq, nk;
    logic              weq, wek;
    logic [DATA_W-1:0] mem_q, mem_k;
    logic              mwq, mwk;
    logic              k_hit, k_done, k_exc;
    logic [CW-1:0]     k_cnt;
    logic [NCACHE-1:0] k_shr;
    logic [NCACHE-1:0] req_bit, others;
    logic [CW-1:0]     others_n;

    logic              n_rsp_v, n_fwd_v, n_fwd_k, n_nack_v;
    logic [IW-1:0]     n_rsp_dst;
    logic [LW-1:0]     n_rsp_line, n_fwd_line;
    logic [DATA_W-1:0] n_rsp_data;
    logic [NCACHE-1:0] n_fwd_mask;

    hdir_store #(.DEPTH(NLINES), .WIDTH(EW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(req_line), .ra_data(eq_raw),
        .rb_addr(ack_line), .rb_data(ek_raw),
        .wa_en(weq), .wa_addr(req_line), .wa_data(nq),
        .wb_en(wek), .wb_addr(ack_line), .wb_data(nk)
    );

    hdir_store #(.DEPTH(NLINES), .WIDTH(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(req_line), .ra_data(mem_q),
        .rb_addr(ack_line), .rb_data(mem_k),
        .wa_en(mwq), .wa_addr(req_line), .wa_data(req_data),
        .wb_en(mwk), .wb_addr(ack_line), .wb_data(ack_data)
    );

    assign eq = dent_t'(eq_raw);
    assign ek = dent_t'(ek_raw);

    hdir_ack_unit #(.NCACHE(NCACHE)) u_ack (
        .ack_valid(ack_valid), .ack_src(ack_src),
        .busy(ek.busy), .cnt(ek.cnt), .rqid(ek.rqid),
        .rqwr(ek.rqwr), .wdat(ek.wdat), .shr(ek.shr),
        .hit(k_hit), .done(k_done), .cnt_nx(k_cnt),
        .fin_shr(k_shr), .fin_exc(k_exc)
    );

    // Requester bit, other sharers and their count.
    always_comb begin
        req_bit          = '0;
        req_bit[req_src] = 1'b1;
        others           = eq.shr & ~req_bit;
        others_n         = '0;
        for (int i = 0; i < NCACHE; i++) begin
            others_n = others_n + CW'(others[i]);
        end
    end

    // Next entry, memory writes and outgoing messages for this cycle.
    always_comb begin
        nq = eq;  weq = 1'b0;  mwq = 1'b0;
        nk = ek;  wek = 1'b0;  mwk = 1'b0;
        n_rsp_v = 1'b0;  n_rsp_dst = req_src;  n_rsp_line = req_line;  n_rsp_data = mem_q;
        n_fwd_v = 1'b0;  n_fwd_k = FW_INV;  n_fwd_mask = '0;  n_fwd_line = req_line;
        n_nack_v = 1'b0;

        if (k_hit) begin
            wek = 1'b1;
            mwk = ek.wdat;
            if (k_done) begin
                nk.st   = k_exc ? LN_EXC : LN_SHR;
                nk.shr  = k_shr;
                nk.busy = 1'b0;
                nk.cnt  = '0;
                n_rsp_v    = 1'b1;
                n_rsp_dst  = ek.rqid;
                n_rsp_line = ack_line;
                n_rsp_data = ek.wdat ? ack_data : mem_k;
            end else begin
                nk.cnt = k_cnt;
            end
        end

        if (req_valid) begin
            if (eq.busy || k_done) begin
                n_nack_v = 1'b1;
            end else begin
                unique case (req_kind_e'(req_type))
                    RQ_READ, RQ_WRITE: begin
                        if (eq.st == LN_UNC || (eq.st == LN_EXC && eq.shr[req_src])
                            || (eq.st == LN_SHR && (req_type == RQ_READ || others == '0))) begin
                            n_rsp_v = 1'b1;
                            weq     = 1'b1;
                            if (req_type == RQ_READ && eq.st != LN_EXC) begin
                                nq.st  = LN_SHR;
                                nq.shr = (eq.st == LN_UNC) ? req_bit : (eq.shr | req_bit);
                            end else begin
                                nq.st  = LN_EXC;
                                nq.shr = req_bit;
                            end
                        end else begin
                            weq        = 1'b1;
                            nq.busy    = 1'b1;
                            nq.rqid    = req_src;
                            nq.rqwr    = (req_type == RQ_WRITE);
                            nq.wdat    = (eq.st == LN_EXC);
                            nq.cnt     = (eq.st == LN_EXC) ? CW'(1) : others_n;
                            n_fwd_v    = 1'b1;
                            n_fwd_k    = (req_type == RQ_READ) ? FW_FETCH : FW_INV;
                            n_fwd_mask = (eq.st == LN_EXC) ? eq.shr : others;
                        end
                    end
                    RQ_WBACK: begin
                        if (eq.st == LN_EXC && eq.shr[req_src]) begin
                            weq    = 1'b1;
                            mwq    = 1'b1;
                            nq.st  = LN_UNC;
                            nq.shr = '0;
                        end
                    end
                    RQ_EVICT: begin
                        if (eq.st == LN_SHR) begin
                            weq    = 1'b1;
                            nq.shr = eq.shr & ~req_bit;
                            nq.st  = (others == '0) ? LN_UNC : LN_SHR;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register the three outgoing message channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;  rsp_dst   <= '0;  rsp_line <= '0;  rsp_data <= '0;
            fwd_valid  <= 1'b0;  fwd_kind  <= 1'b0; fwd_mask <= '0; fwd_line <= '0;
            nack_valid <= 1'b0;  nack_dst  <= '0;  nack_line <= '0;
        end else begin
            rsp_valid  <= n_rsp_v;  rsp_dst  <= n_rsp_dst;  rsp_line <= n_rsp_line;
            rsp_data   <= n_rsp_data;
            fwd_valid  <= n_fwd_v;  fwd_kind <= n_fwd_k;    fwd_mask <= n_fwd_mask;
            fwd_line   <= n_fwd_line;
            nack_valid <= n_nack_v; nack_dst <= req_src;    nack_line <= req_line;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rsp_valid && !fwd_valid && !nack_valid));

    a_r8_busy_line_nacked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eq.busy) |=> (nack_valid && nack_dst == $past(req_src)));

    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eq.st == LN_EXC) |-> ($countones(eq.shr) == 1));

    a_r4_fwd_has_target: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_mask != '0));

    a_r6_fetch_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_kind == FW_FETCH) |-> ($countones(fwd_mask) == 1));
endmodule

// File: tb/hdir_ctrl_tb.sv
// Directed bench for hdir_ctrl: one task per scenario, each checking itself.
module hdir_ctrl_tb;
    localparam int NC = 4;
    localparam int NL = 8;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_type = '0;
    logic [IW-1:0] req_src = '0;
    logic [LW-1:0] req_line = '0;
    logic [DW-1:0] req_data = '0;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_src = '0;
    logic [LW-1:0] ack_line = '0;
    logic [DW-1:0] ack_data = '0;
    logic          rsp_valid, fwd_valid, fwd_kind, nack_valid;
    logic [IW-1:0] rsp_dst, nack_dst;
    logic [LW-1:0] rsp_line, fwd_line, nack_line;
    logic [DW-1:0] rsp_data;
    logic [NC-1:0] fwd_mask;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    hdir_ctrl #(.NCACHE(NC), .NLINES(NL), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type), .req_src(req_src),
        .req_line(req_line), .req_data(req_data),
        .ack_valid(ack_valid), .ack_src(ack_src), .ack_line(ack_line), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_line(rsp_line), .rsp_data(rsp_data),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_mask(fwd_mask), .fwd_line(fwd_line),
        .nack_valid(nack_valid), .nack_dst(nack_dst), .nack_line(nack_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present a request for one cycle; outputs are then valid.
    task automatic req(input logic [1:0] t, input int s, input int l, input logic [DW-1:0] d);
        req_valid = 1'b1; req_type = t; req_src = IW'(s); req_line = LW'(l); req_data = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic ack(input int s, input int l, input logic [DW-1:0] d);
        ack_valid = 1'b1; ack_src = IW'(s); ack_line = LW'(l); ack_data = d;
        @(posedge clk); #1;
        ack_valid = 1'b0;
    endtask

    task automatic exp_rsp(input string tag, input int dst, input int l, input logic [DW-1:0] d);
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " rsp_dst"}, 32'(rsp_dst), 32'(dst));
        chk({tag, " rsp_line"}, 32'(rsp_line), 32'(l));
        chk({tag, " rsp_data"}, 32'(rsp_data), 32'(d));
    endtask

    task automatic exp_fwd(input string tag, input logic k, input logic [NC-1:0] m, input int l);
        chk({tag, " fwd_valid"}, 32'(fwd_valid), 32'd1);
        chk({tag, " fwd_kind"}, 32'(fwd_kind), 32'(k));
        chk({tag, " fwd_mask"}, 32'(fwd_mask), 32'(m));
        chk({tag, " fwd_line"}, 32'(fwd_line), 32'(l));
    endtask

    task automatic exp_quiet(input string tag, input logic r, input logic f, input logic n);
        if (r) chk({tag, " no rsp"}, 32'(rsp_valid), 32'd0);
        if (f) chk({tag, " no fwd"}, 32'(fwd_valid), 32'd0);
        if (n) chk({tag, " no nack"}, 32'(nack_valid), 32'd0);
    endtask

    task automatic t_reset_and_read;
        exp_quiet("R1 after reset", 1, 1, 1);
        req(2'd0, 0, 0, '0);
        exp_rsp("R1 R2 read uncached", 0, 0, 16'h0000);
        exp_quiet("R2 read uncached", 0, 1, 1);
        req(2'd0, 1, 0, '0);
        exp_rsp("R2 read shared", 1, 0, 16'h0000);
        exp_quiet("R2 read shared", 0, 1, 1);
    endtask

    task automatic t_write_shared;
        req(2'd1, 2, 0, '0);
        exp_fwd("R4 invalidate sharers", 1'b0, 4'b0011, 0);
        exp_quiet("R4 no early reply", 1, 0, 1);
        req(2'd0, 3, 0, '0);
        chk("R8 nack valid", 32'(nack_valid), 32'd1);
        chk("R8 nack dst", 32'(nack_dst), 32'd3);
        chk("R8 nack line", 32'(nack_line), 32'd0);
        exp_quiet("R8 nack only", 1, 1, 0);
        ack(0, 0, '0);
        exp_quiet("R4 first ack", 1, 0, 0);
        ack(3, 0, '0);
        exp_quiet("R4 stray ack ignored", 1, 0, 0);
        ack(1, 0, '0);
        exp_rsp("R4 grant after last ack", 2, 0, 16'h0000);
    endtask

    task automatic t_writeback;
        req(2'd2, 1, 0, 16'h1111);
        exp_quiet("R7 non-owner wb", 1, 1, 1);
        req(2'd2, 2, 0, 16'hBEEF);
        exp_quiet("R7 owner wb", 1, 1, 1);
        req(2'd1, 3, 0, '0);
        exp_rsp("R7 R3 write after wb", 3, 0, 16'hBEEF);
        exp_quiet("R3 no forward", 0, 1, 1);
    endtask

    task automatic t_owner_again;
        req(2'd1, 3, 0, '0);
        exp_rsp("R11 owner write", 3, 0, 16'hBEEF);
        exp_quiet("R11 owner write", 0, 1, 1);
        req(2'd0, 3, 0, '0);
        exp_rsp("R11 owner read", 3, 0, 16'hBEEF);
        exp_quiet("R11 owner read", 0, 1, 1);
    endtask

    task automatic t_fetch;
        req(2'd0, 1, 0, '0);
        exp_fwd("R6 fetch owner", 1'b1, 4'b1000, 0);
        exp_quiet("R6 no early reply", 1, 0, 1);
        ack(3, 0, 16'hCAFE);
        exp_rsp("R6 forward data", 1, 0, 16'hCAFE);
        req(2'd1, 0, 0, '0);
        exp_fwd("R6 both now sharers", 1'b0, 4'b1010, 0);
        ack(1, 0, '0);
        exp_quiet("R6 one of two acks", 1, 0, 0);
        ack(3, 0, '0);
        exp_rsp("R6 memory updated", 0, 0, 16'hCAFE);
    endtask

    task automatic t_steal;
        req(2'd1, 2, 0, '0);
        exp_fwd("R5 invalidate owner", 1'b0, 4'b0001, 0);
        ack(0, 0, 16'h1234);
        exp_rsp("R5 owner data to requester", 2, 0, 16'h1234);
        req(2'd1, 2, 0, '0);
        exp_rsp("R5 new sole owner", 2, 0, 16'h1234);
        exp_quiet("R5 new sole owner", 0, 1, 1);
    endtask

    task automatic t_evict;
        req(2'd0, 0, 1, '0);
        req(2'd0, 1, 1, '0);
        req(2'd3, 0, 1, '0);
        exp_quiet("R10 evict silent", 1, 1, 1);
        req(2'd1, 2, 1, '0);
        exp_fwd("R10 evicted bit cleared", 1'b0, 4'b0010, 1);
        ack(1, 1, '0);
        exp_rsp("R10 grant", 2, 1, 16'h0000);
        req(2'd0, 3, 2, '0);
        req(2'd3, 3, 2, '0);
        req(2'd1, 1, 2, '0);
        exp_rsp("R10 empty becomes uncached", 1, 2, 16'h0000);
        exp_quiet("R10 empty becomes uncached", 0, 1, 1);
    endtask

    task automatic t_collide;
        req(2'd0, 0, 3, '0);
        req(2'd1, 1, 3, '0);
        exp_fwd("R9 setup", 1'b0, 4'b0001, 3);
        ack_valid = 1'b1; ack_src = 2'd0; ack_line = 3'd3; ack_data = '0;
        req_valid = 1'b1; req_type = 2'd0; req_src = 2'd2; req_line = 3'd4;
        @(posedge clk); #1;
        ack_valid = 1'b0; req_valid = 1'b0;
        exp_rsp("R9 completion reply", 1, 3, 16'h0000);
        chk("R9 colliding nack", 32'(nack_valid), 32'd1);
        chk("R9 nack dst", 32'(nack_dst), 32'd2);
        chk("R9 nack line", 32'(nack_line), 32'd4);
        req(2'd0, 2, 4, '0);
        exp_rsp("R9 retry served", 2, 4, 16'h0000);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset_and_read();
        t_write_shared();
        t_writeback();
        t_owner_again();
        t_fetch();
        t_steal();
        t_evict();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule